// File: doc/BRIEF.md
# Video Memory CPU Access Bridge

This block sits between an 8-bit processor bus and two video memories: a byte-wide page memory, which holds the character code for each screen cell, and a 9-bit character-shape memory. It decodes each processor address into one of two windows. The character window is fixed. The page window is 1 KB in normal mode and 2 KB in wide mode. The block then raises the matching read or write strobe with a window-relative word address. On a character write, the processor's single-bit Q flag is sampled in the same cycle and becomes bit 8 of the stored word.

The memories may only be touched while the raster is in its blanking (non-display) interval. The block passes that interval to the processor as a pollable flag. Any read or write that lands in a window while the picture is being drawn is dropped and sets a sticky violation bit. Software clears that bit with a clear pulse. Character reads return the low byte on the data bus. The ninth bit of the last permitted character read is held on a separate output.

Top module: `vmb_bridge`

## Requirements
- R1: An access to addresses 0xF400..0xF7FF during blanking strobes the character memory with word address (addr - 0xF400), 10 bits.
- R2: With wide mode off, addresses 0xF800..0xFBFF map to the page memory at (addr - 0xF800); 0xFC00 and above produce no strobe.
- R3: With wide mode on, addresses 0xF800..0xFFFF map to the page memory at (addr - 0xF800), 11 bits.
- R4: A character write stores {Q, data byte} as the 9-bit word; bit 8 is Q in that same cycle.
- R5: The status flag output follows the blanking input in every cycle.
- R6: A read or write that hits either window while blanking is low raises no strobe, does not drive the data bus, and sets the violation output from the next cycle on.
- R7: The violation output stays set until a clear pulse, which takes effect the next cycle; a violation in the same cycle as a clear leaves it set.
- R8: A permitted read drives the low 8 bits of the selected memory onto the read data bus with the output-enable high; otherwise the enable is low.
- R9: The bit-8 output shows bit 8 of the most recent permitted character read, from the cycle after that read, and holds otherwise.
- R10: An address outside both windows causes no strobe, no bus drive and no violation.
- R11: If read and write are requested together, only the write is performed.
- R12: After reset the violation and bit-8 outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_q | input | 1 | Processor Q flag, source of bit 8 |
| wide_mode | input | 1 | 1 selects the 2 KB page window |
| blank_i | input | 1 | High during the non-display interval |
| viol_clr | input | 1 | Clears the sticky violation bit |
| ef1_o | output | 1 | Blanking status flag for the processor |
| cpu_rdata | output | 8 | Read data to the processor |
| cpu_rdata_oe | output | 1 | Read data bus drive enable |
| viol_o | output | 1 | Sticky access violation |
| ch_bit8_o | output | 1 | Bit 8 of the last permitted character read |
| pg_we | output | 1 | Page memory write strobe |
| pg_re | output | 1 | Page memory read strobe |
| pg_addr | output | 11 | Page memory word address |
| pg_wdata | output | 8 | Page memory write data |
| pg_rdata | input | 8 | Page memory read data |
| ch_we | output | 1 | Character memory write strobe |
| ch_re | output | 1 | Character memory read strobe |
| ch_addr | output | 10 | Character memory word address |
| ch_wdata | output | 9 | Character memory write data |
| ch_rdata | input | 9 | Character memory read data |

## Verification
The bench probes the window edges 0xF3FF, 0xF400, 0xF7FF, 0xF800, 0xFBFF, 0xFC00 and 0xFFFF in both page modes. An off-by-one decode would strobe the wrong memory or leave an edge address dead. It writes during active display and then reads the same word back during blanking. A design that only flagged the error but still wrote would return altered data. It pulses clear in the same cycle as a fresh violation, which catches a clear-wins priority, and it issues read and write together, which exposes a design that strobes both. Writes with Q both high and low, read back later, show whether bit 8 was sampled with the data or taken from a stale value.

// File: rtl/vmb_pkg.sv
package vmb_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CHAR = 2'd1,
    RG_PAGE = 2'd2
  } vmb_region_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } vmb_op_e;

  // base <= a < base + size, done without overflow
  function automatic logic win_hit(input int unsigned a, input int unsigned base,
                                   input int unsigned size);
    return (a >= base) && ((a - base) < size);
  endfunction

  // write has precedence over read
  function automatic vmb_op_e op_of(input logic rd, input logic wr);
    if (wr) return OP_WRITE;
    if (rd) return OP_READ;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/vmb_decode.sv
module vmb_decode
  import vmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CHR_BASE = 16'hF400,
  parameter int CHR_WORDS = 1024,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hF800,
  parameter int PAGE_NARROW = 1024,
  parameter int PAGE_WIDE = 2048,
  localparam int CHR_AW = $clog2(CHR_WORDS),
  localparam int PG_AW = $clog2(PAGE_WIDE)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output vmb_region_e       region,
  output logic [CHR_AW-1:0] chr_off,
  output logic [PG_AW-1:0]  pg_off
);

  logic chr_hit, pg_hit;
  int unsigned pg_size;

  always_comb begin
    pg_size = wide ? PAGE_WIDE : PAGE_NARROW;
    chr_hit = win_hit(32'(addr), 32'(CHR_BASE), CHR_WORDS);
    pg_hit  = win_hit(32'(addr), 32'(PAGE_BASE), pg_size);
    if (chr_hit)     region = RG_CHAR;
    else if (pg_hit) region = RG_PAGE;
    else             region = RG_NONE;
  end

  assign chr_off = addr[CHR_AW-1:0] - CHR_BASE[CHR_AW-1:0];
  assign pg_off  = addr[PG_AW-1:0] - PAGE_BASE[PG_AW-1:0];

endmodule

// File: rtl/vmb_gate.sv
module vmb_gate
  import vmb_pkg::*;
(
  input  vmb_region_e region,
  input  vmb_op_e     op,
  input  logic        blank,
  output logic        pg_we,
  output logic        pg_re,
  output logic        ch_we,
  output logic        ch_re,
  output logic        acc_ok,
  output logic        viol_ev
);

  logic hit, req;

  assign hit     = (region != RG_NONE);
  assign req     = (op != OP_IDLE);
  assign acc_ok  = hit && req && blank;
  assign viol_ev = hit && req && !blank;

  assign pg_we = acc_ok && (region == RG_PAGE) && (op == OP_WRITE);
  assign pg_re = acc_ok && (region == RG_PAGE) && (op == OP_READ);
  assign ch_we = acc_ok && (region == RG_CHAR) && (op == OP_WRITE);
  assign ch_re = acc_ok && (region == RG_CHAR) && (op == OP_READ);

endmodule

// File: rtl/vmb_status.sv
module vmb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_ev,
  input  logic viol_clr,
  input  logic bit8_cap,
  input  logic bit8_in,
  output logic viol_q,
  output logic bit8_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      bit8_q <= 1'b0;
    end else begin
      if (viol_ev)       viol_q <= 1'b1;
      else if (viol_clr) viol_q <= 1'b0;
      if (bit8_cap)      bit8_q <= bit8_in;
    end
  end

endmodule

// File: rtl/vmb_bridge.sv
module vmb_bridge
  import vmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CHR_BASE = 16'hF400,
  parameter int CHR_WORDS = 1024,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hF800,
  parameter int PAGE_NARROW = 1024,
  parameter int PAGE_WIDE = 2048,
  localparam int CHR_AW = $clog2(CHR_WORDS),
  localparam int PG_AW = $clog2(PAGE_WIDE),
  localparam int CHR_DW = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_q,
  input  logic              wide_mode,
  input  logic              blank_i,
  input  logic              viol_clr,
  output logic              ef1_o,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              viol_o,
  output logic              ch_bit8_o,
  output logic              pg_we,
  output logic              pg_re,
  output logic [PG_AW-1:0]  pg_addr,
  output logic [DATA_W-1:0] pg_wdata,
  input  logic [DATA_W-1:0] pg_rdata,
  output logic              ch_we,
  output logic              ch_re,
  output logic [CHR_AW-1:0] ch_addr,
  output logic [CHR_DW-1:0] ch_wdata,
  input  logic [CHR_DW-1:0] ch_rdata
);

  vmb_region_e region;
  vmb_op_e     op;
  logic        acc_ok;
  logic        viol_ev;

  assign op = op_of(cpu_rd, cpu_wr);

  vmb_decode #(
    .ADDR_W(ADDR_W), .CHR_BASE(CHR_BASE), .CHR_WORDS(CHR_WORDS),
    .PAGE_BASE(PAGE_BASE), .PAGE_NARROW(PAGE_NARROW), .PAGE_WIDE(PAGE_WIDE)
  ) u_dec (
    .addr(cpu_addr), .wide(wide_mode), .region(region),
    .chr_off(ch_addr), .pg_off(pg_addr)
  );

  vmb_gate u_gate (
    .region(region), .op(op), .blank(blank_i),
    .pg_we(pg_we), .pg_re(pg_re), .ch_we(ch_we), .ch_re(ch_re),
    .acc_ok(acc_ok), .viol_ev(viol_ev)
  );

  vmb_status u_stat (
    .clk(clk), .rst_n(rst_n), .viol_ev(viol_ev), .viol_clr(viol_clr),
    .bit8_cap(ch_re), .bit8_in(ch_rdata[CHR_DW-1]),
    .viol_q(viol_o), .bit8_q(ch_bit8_o)
  );

  assign ef1_o    = blank_i;
  assign pg_wdata = cpu_wdata;
  assign ch_wdata = {cpu_q, cpu_wdata};

  always_comb begin
    if (ch_re)      cpu_rdata = ch_rdata[DATA_W-1:0];
    else if (pg_re) cpu_rdata = pg_rdata;
    else            cpu_rdata = '0;
  end
  assign cpu_rdata_oe = ch_re || pg_re;

endmodule

// File: rtl/vmb_chk.sv
module vmb_chk (
  input logic clk,
  input logic rst_n,
  input logic blank_i,
  input logic cpu_q,
  input logic cpu_wr,
  input logic viol_clr,
  input logic viol_ev,
  input logic acc_ok,
  input logic viol_o,
  input logic pg_we,
  input logic pg_re,
  input logic ch_we,
  input logic ch_re,
  input logic ch_wdata_top
);

  // R4
  bit8_from_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_we |-> (ch_wdata_top == cpu_q));

  // R6
  viol_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_ev |=> viol_o);

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && !viol_ev && !viol_clr) |=> viol_o);

  // R7
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !viol_ev) |=> !viol_o);

  // R6
  strobe_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_we || pg_re || ch_we || ch_re) |-> (blank_i && acc_ok && !viol_ev));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_we, pg_re, ch_we, ch_re}));

  // R11
  read_not_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_re || ch_re) |-> !cpu_wr);

endmodule

bind vmb_bridge vmb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .cpu_q(cpu_q), .cpu_wr(cpu_wr),
  .viol_clr(viol_clr), .viol_ev(viol_ev), .acc_ok(acc_ok), .viol_o(viol_o),
  .pg_we(pg_we), .pg_re(pg_re), .ch_we(ch_we), .ch_re(ch_re),
  .ch_wdata_top(ch_wdata[CHR_DW-1])
);

// File: tb/vmb_bridge_tb.sv
`timescale 1ns/1ps
module vmb_bridge_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_rd = 0, cpu_wr = 0, cpu_q = 0, wide_mode = 0, blank_i = 0, viol_clr = 0;
  logic ef1_o, cpu_rdata_oe, viol_o, ch_bit8_o, pg_we, pg_re, ch_we, ch_re;
  logic [7:0]  cpu_rdata, pg_wdata, pg_rdata;
  logic [10:0] pg_addr;
  logic [9:0]  ch_addr;
  logic [8:0]  ch_wdata, ch_rdata;

  logic [7:0] pg_mem [2048];
  logic [8:0] ch_mem [1024];
  logic [7:0] sh_pg [2048];
  logic [8:0] sh_ch [1024];

  assign pg_rdata = pg_mem[pg_addr];
  assign ch_rdata = ch_mem[ch_addr];

  always @(posedge clk) begin
    if (pg_we) pg_mem[pg_addr] <= pg_wdata;
    if (ch_we) ch_mem[ch_addr] <= ch_wdata;
  end

  vmb_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_q(cpu_q), .wide_mode(wide_mode),
    .blank_i(blank_i), .viol_clr(viol_clr), .ef1_o(ef1_o), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .viol_o(viol_o), .ch_bit8_o(ch_bit8_o),
    .pg_we(pg_we), .pg_re(pg_re), .pg_addr(pg_addr), .pg_wdata(pg_wdata),
    .pg_rdata(pg_rdata), .ch_we(ch_we), .ch_re(ch_re), .ch_addr(ch_addr),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata)
  );

  typedef struct {
    logic [3:0]  stb;   // {pg_we, pg_re, ch_we, ch_re}
    logic [10:0] pa;
    logic [9:0]  ca;
    logic [8:0]  cw;
    logic [7:0]  pw;
    logic        oe;
    logic [7:0]  rd;
    logic        viol;
    logic        b8;
    logic        ef1;
    string       req;
  } item_t;

  item_t exp_q[$];
  int n_tests = 0;
  int n_fail = 0;
  logic m_viol = 0;
  logic m_b8 = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected response
  task automatic acc(input logic [15:0] a, input logic rd, input logic wr,
                     input logic q, input logic [7:0] d, input logic blank,
                     input logic wide, input logic clr, input string req);
    item_t it;
    logic is_ch, is_pg, hit, req_any, ok, ev;
    logic [9:0] ci;
    logic [10:0] pi;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_q = q; cpu_wdata = d;
    blank_i = blank; wide_mode = wide; viol_clr = clr;
    is_ch = (a >= 16'hF400) && (a <= 16'hF7FF);
    is_pg = (a >= 16'hF800) && (wide || (a <= 16'hFBFF));
    hit = is_ch || is_pg;
    req_any = rd || wr;
    ok = hit && req_any && blank;
    ev = hit && req_any && !blank;
    ci = 10'(a - 16'hF400);
    pi = 11'(a - 16'hF800);
    it.stb = {ok && is_pg && wr, ok && is_pg && !wr, ok && is_ch && wr, ok && is_ch && !wr};
    it.pa = pi; it.ca = ci; it.cw = {q, d}; it.pw = d;
    it.oe = ok && !wr;
    it.rd = !it.oe ? 8'h00 : (is_ch ? sh_ch[ci][7:0] : sh_pg[pi]);
    it.viol = m_viol; it.b8 = m_b8; it.ef1 = blank; it.req = req;
    exp_q.push_back(it);
    if (ok && wr && is_ch) sh_ch[ci] = {q, d};
    if (ok && wr && is_pg) sh_pg[pi] = d;
    if (ok && !wr && is_ch) m_b8 = sh_ch[ci][8];
    if (ev) m_viol = 1'b1;
    else if (clr) m_viol = 1'b0;
  endtask

  task automatic idle(input logic blank, input string req);
    acc(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, blank, 1'b0, 1'b0, req);
  endtask

  // monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      chk(e.req, "strobes", 32'({pg_we, pg_re, ch_we, ch_re}), 32'(e.stb));
      if (e.stb[3] || e.stb[2]) chk(e.req, "pg_addr", 32'(pg_addr), 32'(e.pa));
      if (e.stb[1] || e.stb[0]) chk(e.req, "ch_addr", 32'(ch_addr), 32'(e.ca));
      if (e.stb[1]) chk(e.req, "ch_wdata", 32'(ch_wdata), 32'(e.cw));
      if (e.stb[3]) chk(e.req, "pg_wdata", 32'(pg_wdata), 32'(e.pw));
      chk(e.req, "rdata_oe", 32'(cpu_rdata_oe), 32'(e.oe));
      if (e.oe) chk(e.req, "rdata", 32'(cpu_rdata), 32'(e.rd));
      chk(e.req, "viol", 32'(viol_o), 32'(e.viol));
      chk(e.req, "bit8", 32'(ch_bit8_o), 32'(e.b8));
      chk(e.req, "ef1", 32'(ef1_o), 32'(e.ef1));
    end
  end

  logic done = 0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin pg_mem[i] = 8'h00; sh_pg[i] = 8'h00; end
    for (int i = 0; i < 1024; i++) begin ch_mem[i] = 9'h000; sh_ch[i] = 9'h000; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state, R5 flag follows blanking
    idle(1'b0, "R12");
    idle(1'b1, "R5");
    idle(1'b0, "R5");
    // R1 R4 character writes at both edges, Q high and low
    acc(16'hF400, 0, 1, 1, 8'hA5, 1, 0, 0, "R1");
    acc(16'hF7FF, 0, 1, 0, 8'h3C, 1, 0, 0, "R4");
    acc(16'hF512, 0, 1, 1, 8'h00, 1, 0, 0, "R4");
    // R2 normal page window
    acc(16'hF800, 0, 1, 0, 8'h11, 1, 0, 0, "R2");
    acc(16'hFBFF, 0, 1, 0, 8'h22, 1, 0, 0, "R2");
    acc(16'hFC00, 0, 1, 0, 8'h33, 1, 0, 0, "R2");
    // R3 wide page window
    acc(16'hFC00, 0, 1, 0, 8'h44, 1, 1, 0, "R3");
    acc(16'hFFFF, 0, 1, 1, 8'h55, 1, 1, 0, "R3");
    // R8 R9 reads
    acc(16'hF400, 1, 0, 0, 8'h00, 1, 0, 0, "R8");
    idle(1'b1, "R9");
    acc(16'hF7FF, 1, 0, 0, 8'h00, 1, 0, 0, "R9");
    acc(16'hF512, 1, 0, 0, 8'h00, 1, 0, 0, "R9");
    acc(16'hFBFF, 1, 0, 0, 8'h00, 1, 0, 0, "R8");
    acc(16'hFFFF, 1, 0, 0, 8'h00, 1, 1, 0, "R3");
    acc(16'hFFFF, 1, 0, 0, 8'h00, 1, 0, 0, "R2");
    // R10 out of window
    acc(16'h1234, 1, 0, 0, 8'h00, 1, 0, 0, "R10");
    acc(16'hF3FF, 0, 1, 1, 8'h77, 1, 0, 0, "R10");
    acc(16'hF3FF, 1, 0, 0, 8'h00, 0, 0, 0, "R10");
    idle(1'b1, "R10");
    // R11 read and write together
    acc(16'hF600, 1, 1, 1, 8'h9C, 1, 0, 0, "R11");
    acc(16'hF600, 1, 0, 0, 8'h00, 1, 0, 0, "R11");
    // R6 write during active display is dropped and flagged
    acc(16'hF400, 0, 1, 0, 8'hFF, 0, 0, 0, "R6");
    idle(1'b0, "R6");
    idle(1'b1, "R7");
    acc(16'hF400, 1, 0, 0, 8'h00, 1, 0, 0, "R6");
    acc(16'hF900, 1, 0, 0, 8'h00, 0, 0, 0, "R6");
    // R7 clear, then clear colliding with a violation
    acc(16'h0000, 0, 0, 0, 8'h00, 1, 0, 1, "R7");
    idle(1'b1, "R7");
    acc(16'hFE00, 0, 1, 0, 8'h66, 0, 1, 1, "R7");
    idle(1'b1, "R7");
    acc(16'h0000, 0, 0, 0, 8'h00, 1, 0, 1, "R7");
    idle(1'b1, "R7");
    acc(16'hFE00, 1, 0, 0, 8'h00, 1, 1, 0, "R6");
    idle(1'b1, "R12");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule